// File: doc/BRIEF.md
# Requester ID to MSI Sideband Translator

This block sits beside the inbound write path of a PCI root complex. Each message-signalled interrupt write carries a 16-bit requester ID: bus in bits [15:8], device in bits [7:3] and function in bits [2:0]. The block first ANDs the ID with a programmable mask. It then compares the masked value against a small table of range entries. Every entry names one target interrupt controller. An entry matches when the masked ID lies inside its half-open interval. A match relocates the ID by a base-plus-offset sum into the sideband value that goes to that controller.

Several entries may cover the same ID while naming different controllers, so one write can fan out to several controllers in the same lookup. Each of those controllers gets its own translated value. A controller that no valid entry names is never selected. When two valid entries for the same controller both match, the entry with the lower index supplies the value.

Software loads the mask and the table through a plain register write port. A lookup starts with a one-cycle request strobe, and the hit vector, the per-controller sideband values and a no-match flag appear on registered outputs one clock later.

Top module: `rid_msi_xlate`

## Requirements
- R1: After reset every table entry is invalid and the mask is 0xFFFF, so any request gets rsp_hit equal to zero and rsp_no_match set.
- R2: The lookup uses req_rid AND mask. The mask register is written at wr_addr bit 5 = 1, with the mask in wr_data[15:0].
- R3: An entry matches a masked ID r only when rid_base <= r < rid_base + length. The top bound is excluded, and a length of zero never matches.
- R4: A matching entry yields the sideband value (r - rid_base + sb_base) modulo 2^16.
- R5: When entries for different controllers cover the same ID, every one of those controllers reports a hit, each with its own translated value.
- R6: A controller that no valid entry targets never reports a hit.
- R7: If several valid entries for the same controller match, the entry with the lowest index sets that controller's sideband value.
- R8: The length field is 17 bits wide. A length of 0x10000 at base 0x0000 covers every ID, with no overflow in the bound compare.
- R9: Two entries of length 0x8000 that map base 0x0000 to 0x8000 and base 0x8000 to 0x0000 for one controller together invert bit 15 of the ID.
- R10: rsp_valid is high for exactly the cycle after each cycle with req_valid high. The response outputs change only after a request and hold their values otherwise.
- R11: rsp_no_match is set exactly when no controller hits. The sideband value of a controller that does not hit is zero.
- R12: For entries, wr_addr bit 5 = 0, bits [4:2] give the entry index and bits [1:0] the field: 0 = rid base (data[15:0]), 1 = sideband base (data[15:0]), 2 = length (data[16:0]), 3 = control (valid in data[31], target controller in data[3:0]). A write in the same cycle as a request does not affect that request.
- R13: An entry whose valid bit is clear takes no part in matching, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address: mask select, entry index and field |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_rid | input | 16 | Requester ID of the interrupt write |
| rsp_valid | output | 1 | Response valid, one clock after a request |
| rsp_hit | output | 4 | Per-controller hit bits |
| rsp_sideband | output | 64 | Per-controller sideband values, controller c in bits [16c+15:16c] |
| rsp_no_match | output | 1 | Set when no controller hit |

## Verification
A table write and a lookup can fall in the same clock. The bench provokes this by disabling the entry that serves controller 1 in the very cycle it strobes a request for an ID that entry covers. The response must still show the pre-write hit and value for controller 1. The bench then repeats the same request one cycle later, and this time controller 1 must miss while the other controllers are unaffected.

// File: rtl/rid_xlate_pkg.sv
package rid_xlate_pkg;

  localparam int RID_W   = 16;
  localparam int SB_W    = 16;
  localparam int LEN_W   = RID_W + 1;
  localparam int DATA_W  = 32;
  localparam int CTRL_FW = 4;
  localparam int VALID_BIT = DATA_W - 1;

  typedef enum logic [1:0] {
    FLD_RID_BASE = 2'd0,
    FLD_SB_BASE  = 2'd1,
    FLD_LENGTH   = 2'd2,
    FLD_CONTROL  = 2'd3
  } field_e;

  typedef struct packed {
    logic               valid;
    logic [CTRL_FW-1:0] ctrl;
    logic [RID_W-1:0]   rid_base;
    logic [SB_W-1:0]    sb_base;
    logic [LEN_W-1:0]   len;
  } map_entry_t;

endpackage

// File: rtl/rid_map_regs.sv
module rid_map_regs
  import rid_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3,
  parameter int ADDR_W      = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [RID_W-1:0]  mask,
  output map_entry_t        tbl [NUM_ENTRIES]
);

  logic             sel_mask;
  logic [IDX_W-1:0] wr_idx;
  field_e           wr_fld;

  assign sel_mask = wr_addr[ADDR_W-1];
  assign wr_idx   = wr_addr[IDX_W+1:2];
  assign wr_fld   = field_e'(wr_addr[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
    end else if (wr_en && sel_mask) begin
      mask <= wr_data[RID_W-1:0];
    end
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic hit_this;
    assign hit_this = wr_en && !sel_mask && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[e] <= '0;
      end else if (hit_this) begin
        case (wr_fld)
          FLD_RID_BASE: tbl[e].rid_base <= wr_data[RID_W-1:0];
          FLD_SB_BASE:  tbl[e].sb_base  <= wr_data[SB_W-1:0];
          FLD_LENGTH:   tbl[e].len      <= wr_data[LEN_W-1:0];
          FLD_CONTROL: begin
            tbl[e].valid <= wr_data[VALID_BIT];
            tbl[e].ctrl  <= wr_data[CTRL_FW-1:0];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rid_range_match.sv
module rid_range_match
  import rid_xlate_pkg::*;
(
  input  map_entry_t       ent,
  input  logic [RID_W-1:0] rid,
  output logic             hit,
  output logic [SB_W-1:0]  sb
);

  // One bit wider than base + length can reach, so the upper bound never wraps.
  localparam int CMP_W = LEN_W + 1;

  logic [CMP_W-1:0] r_ext;
  logic [CMP_W-1:0] lo_ext;
  logic [CMP_W-1:0] hi_ext;
  logic [RID_W-1:0] offset;

  assign r_ext  = {{(CMP_W-RID_W){1'b0}}, rid};
  assign lo_ext = {{(CMP_W-RID_W){1'b0}}, ent.rid_base};
  assign hi_ext = lo_ext + {{(CMP_W-LEN_W){1'b0}}, ent.len};

  assign hit    = ent.valid && (r_ext >= lo_ext) && (r_ext < hi_ext);
  assign offset = rid - ent.rid_base;
  assign sb     = hit ? (SB_W'(offset) + ent.sb_base) : '0;

endmodule

// File: rtl/rid_ctrl_pick.sv
module rid_ctrl_pick
  import rid_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int CTRL_ID     = 0
) (
  input  map_entry_t             tbl    [NUM_ENTRIES],
  input  logic [NUM_ENTRIES-1:0] ent_hit,
  input  logic [SB_W-1:0]        ent_sb [NUM_ENTRIES],
  output logic                   hit,
  output logic [SB_W-1:0]        sb
);

  // Walk from the top index down so the lowest matching index is written last.
  always_comb begin
    hit = 1'b0;
    sb  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (ent_hit[i] && (tbl[i].ctrl == CTRL_FW'(CTRL_ID))) begin
        hit = 1'b1;
        sb  = ent_sb[i];
      end
    end
  end

endmodule

// File: rtl/rid_msi_xlate.sv
module rid_msi_xlate
  import rid_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_CTRL    = 4,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int ADDR_W     = IDX_W + 3,
  localparam int SBV_W      = NUM_CTRL * SB_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                req_valid,
  input  logic [RID_W-1:0]    req_rid,
  output logic                rsp_valid,
  output logic [NUM_CTRL-1:0] rsp_hit,
  output logic [SBV_W-1:0]    rsp_sideband,
  output logic                rsp_no_match
);

  logic [RID_W-1:0]       mask;
  map_entry_t             tbl    [NUM_ENTRIES];
  logic [RID_W-1:0]       rid_masked;
  logic [NUM_ENTRIES-1:0] ent_hit;
  logic [SB_W-1:0]        ent_sb [NUM_ENTRIES];
  logic [NUM_CTRL-1:0]    pick_hit;
  logic [SBV_W-1:0]       pick_sb;

  rid_map_regs #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W),
    .ADDR_W      (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mask    (mask),
    .tbl     (tbl)
  );

  assign rid_masked = req_rid & mask;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
    rid_range_match u_match (
      .ent (tbl[e]),
      .rid (rid_masked),
      .hit (ent_hit[e]),
      .sb  (ent_sb[e])
    );
  end

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_pick
    rid_ctrl_pick #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .CTRL_ID     (c)
    ) u_pick (
      .tbl     (tbl),
      .ent_hit (ent_hit),
      .ent_sb  (ent_sb),
      .hit     (pick_hit[c]),
      .sb      (pick_sb[c*SB_W +: SB_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= '0;
      rsp_sideband <= '0;
      rsp_no_match <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit      <= pick_hit;
        rsp_sideband <= pick_sb;
        rsp_no_match <= ~|pick_hit;
      end
    end
  end

endmodule

// File: rtl/rid_msi_xlate_chk.sv
module rid_msi_xlate_chk
  import rid_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_CTRL    = 4,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int ADDR_W     = IDX_W + 3,
  localparam int SBV_W      = NUM_CTRL * SB_W
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic                req_valid,
  input logic [RID_W-1:0]    req_rid,
  input logic                rsp_valid,
  input logic [NUM_CTRL-1:0] rsp_hit,
  input logic [SBV_W-1:0]    rsp_sideband,
  input logic                rsp_no_match
);

  // Superset of controllers ever named by an entry written valid since reset.
  logic [(1<<CTRL_FW)-1:0] named_q;
  logic                    ctrl_wr_valid;

  assign ctrl_wr_valid = wr_en && !wr_addr[ADDR_W-1] &&
                         (wr_addr[1:0] == FLD_CONTROL) && wr_data[VALID_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      named_q <= '0;
    end else if (ctrl_wr_valid) begin
      named_q[wr_data[CTRL_FW-1:0]] <= 1'b1;
    end
  end

  assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_hit) && $stable(rsp_sideband) && $stable(rsp_no_match)));

  assert_no_match_flag_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_no_match == (rsp_hit == '0)));

  assert_unnamed_never_hit_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_hit & ~named_q[NUM_CTRL-1:0]) == '0));

  assert_empty_table_R1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (named_q == '0)) |-> rsp_no_match);

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_sb
    assert_zero_sb_on_miss_R11: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_hit[c]) |-> (rsp_sideband[c*SB_W +: SB_W] == '0));
  end

endmodule

bind rid_msi_xlate rid_msi_xlate_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .NUM_CTRL    (NUM_CTRL)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .req_valid    (req_valid),
  .req_rid      (req_rid),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_sideband (rsp_sideband),
  .rsp_no_match (rsp_no_match)
);

// File: tb/rid_msi_xlate_test.sv
module rid_msi_xlate_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_rid = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_hit;
  logic [63:0] rsp_sideband;
  logic        rsp_no_match;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rid_msi_xlate uut (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .req_valid    (req_valid),
    .req_rid      (req_rid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_sideband (rsp_sideband),
    .rsp_no_match (rsp_no_match)
  );

  // {rid, expected hit[3:0], expected sideband ctrl3..ctrl0}
  localparam int NVEC = 14;
  localparam logic [83:0] VEC [NVEC] = '{
    {16'h0000, 4'b0011, 16'h0000, 16'h0000, 16'h0000, 16'h8000}, // R9 R8 R5
    {16'h7FFF, 4'b0011, 16'h0000, 16'h0000, 16'h7FFF, 16'hFFFF}, // R9
    {16'h8000, 4'b0011, 16'h0000, 16'h0000, 16'h8000, 16'h0000}, // R9
    {16'hFFFF, 4'b0111, 16'h0000, 16'h0007, 16'hFFFF, 16'h7FFF}, // R4 wrap, R8
    {16'h1200, 4'b0111, 16'h0000, 16'h0040, 16'h1200, 16'h9200}, // R3 low edge
    {16'h120F, 4'b0111, 16'h0000, 16'h004F, 16'h120F, 16'h920F}, // R3 last
    {16'h1208, 4'b0111, 16'h0000, 16'h0048, 16'h1208, 16'h9208}, // R7
    {16'h1210, 4'b0111, 16'h0000, 16'h0708, 16'h1210, 16'h9210}, // R7 R4
    {16'h11FF, 4'b0011, 16'h0000, 16'h0000, 16'h11FF, 16'h91FF}, // R3 below
    {16'h1307, 4'b0111, 16'h0000, 16'h07FF, 16'h1307, 16'h9307}, // R3 last
    {16'h1308, 4'b0011, 16'h0000, 16'h0000, 16'h1308, 16'h9308}, // R3 excl
    {16'h3000, 4'b0011, 16'h0000, 16'h0000, 16'h3000, 16'hB000}, // R3 len 0
    {16'hFFEF, 4'b0011, 16'h0000, 16'h0000, 16'hFFEF, 16'h7FEF}, // R3
    {16'hFFF0, 4'b0111, 16'h0000, 16'hFFF8, 16'hFFF0, 16'h7FF0}  // R4
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ent_addr(input int idx, input int fld);
    return {1'b0, 3'(idx), 2'(fld)};
  endfunction

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_entry(input int idx, input logic [15:0] base, input logic [15:0] sb,
                           input logic [16:0] len, input logic [3:0] ctrl, input logic vld);
    wr_reg(ent_addr(idx, 0), {16'h0, base});
    wr_reg(ent_addr(idx, 1), {16'h0, sb});
    wr_reg(ent_addr(idx, 2), {15'h0, len});
    wr_reg(ent_addr(idx, 3), {vld, 27'h0, ctrl});
  endtask

  // Strobe one request; return at the negedge after the capturing edge.
  task automatic do_req(input logic [15:0] rid);
    @(negedge clk);
    req_valid = 1'b1; req_rid = rid;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 idle rsp_valid after reset", 64'(rsp_valid), 64'h0);

    // R1: empty table, mask all ones
    do_req(16'h1234);
    check("R1 rsp_valid", 64'(rsp_valid), 64'h1);
    check("R1 hit", 64'(rsp_hit), 64'h0);
    check("R1 no_match", 64'(rsp_no_match), 64'h1);
    check("R1 sideband", rsp_sideband, 64'h0);

    // Configure table (R12 address layout)
    set_entry(0, 16'h0000, 16'h8000, 17'h08000, 4'd0, 1'b1);
    set_entry(1, 16'h8000, 16'h0000, 17'h08000, 4'd0, 1'b1);
    set_entry(2, 16'h0000, 16'h0000, 17'h10000, 4'd1, 1'b1);
    set_entry(3, 16'h1200, 16'h0040, 17'h00010, 4'd2, 1'b1);
    set_entry(4, 16'h1208, 16'h0700, 17'h00100, 4'd2, 1'b1);
    set_entry(5, 16'h3000, 16'h0123, 17'h00000, 4'd2, 1'b1);
    set_entry(6, 16'hFFF0, 16'hFFF8, 17'h00010, 4'd2, 1'b1);
    set_entry(7, 16'h0000, 16'h0000, 17'h10000, 4'd3, 1'b0); // R13 R6: invalid

    for (int i = 0; i < NVEC; i++) begin
      do_req(VEC[i][83:68]);
      check($sformatf("R5 R6 R7 hit vec %0d", i), 64'(rsp_hit), 64'(VEC[i][67:64]));
      check($sformatf("R3 R4 R9 sideband vec %0d", i), rsp_sideband, VEC[i][63:0]);
      check($sformatf("R11 no_match vec %0d", i), 64'(rsp_no_match), 64'h0);
    end

    // R10: outputs hold while idle even as the rid input changes
    req_rid = 16'hAAAA;
    repeat (2) @(negedge clk);
    check("R10 no rsp_valid when idle", 64'(rsp_valid), 64'h0);
    check("R10 sideband held", rsp_sideband, {16'h0000, 16'hFFF8, 16'hFFF0, 16'h7FF0});

    // R2: mask applied before lookup
    wr_reg(6'h20, 32'h0000_00FF);
    do_req(16'h9234);
    check("R2 hit mask 00FF", 64'(rsp_hit), 64'h3);
    check("R2 sideband mask 00FF", rsp_sideband, {16'h0, 16'h0, 16'h0034, 16'h8034});
    wr_reg(6'h20, 32'h0000_FFF0);
    do_req(16'h120F);
    check("R2 hit mask FFF0", 64'(rsp_hit), 64'h7);
    check("R2 sideband mask FFF0", rsp_sideband, {16'h0, 16'h0040, 16'h1200, 16'h9200});
    wr_reg(6'h20, 32'h0000_FFFF);

    // R12: write in the same cycle as a request
    @(negedge clk);
    req_valid = 1'b1; req_rid = 16'h5555;
    wr_en = 1'b1; wr_addr = ent_addr(2, 3); wr_data = {1'b0, 27'h0, 4'd1};
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check("R12 same-cycle write hit", 64'(rsp_hit), 64'h3);
    check("R12 same-cycle write sideband", rsp_sideband, {16'h0, 16'h0, 16'h5555, 16'hD555});
    do_req(16'h5555);
    check("R12 R13 after write hit", 64'(rsp_hit), 64'h1);
    check("R13 after write sideband", rsp_sideband, {16'h0, 16'h0, 16'h0, 16'hD555});

    // R11 R13: disable the controller-0 entries too
    wr_reg(ent_addr(0, 3), 32'h0);
    wr_reg(ent_addr(1, 3), 32'h0);
    do_req(16'h5555);
    check("R11 no hit", 64'(rsp_hit), 64'h0);
    check("R11 no_match set", 64'(rsp_no_match), 64'h1);
    check("R11 sideband zero", rsp_sideband, 64'h0);
    do_req(16'hFFF5);
    check("R11 no_match clear on hit", 64'(rsp_no_match), 64'h0);
    check("R4 sideband ctrl2", rsp_sideband, {16'h0, 16'hFFFD, 16'h0, 16'h0});

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule